// File: doc/BRIEF.md
# Posted Flash Write Buffer

This block sits on the byte-write path between a processor and a flash programming port. A processor write is taken only when a software-armed byte-write enable is set and an external write-permit input allows it. The permit input stands in for the unlock and security checks. The block then either passes the byte straight to the flash port or parks it in a single-entry holding slot.

Parking happens only when the posting control bit is set and the coprocessor-enable input is high. A parked byte stays in the slot until the coprocessor busy input goes from high to low. At that point it is presented to the flash port and held there until the port acknowledges it. While the slot is occupied, a pending status output is high, and further byte writes are dropped.

Each accepted byte clears the arm bit, so software must re-arm before every byte. Software cannot re-arm while the global interrupt enable is high.

Top module: `flash_post_buf`

## Requirements
- R1: After a synchronous active-low reset, `pending`, `arm_q`, `post_q` and `fl_req` are all 0.
- R2: A control write (`ctl_we`=1) always loads `post_q` from `ctl_post`. It loads `arm_q` from `ctl_arm` only when `irq_en`=0; with `irq_en`=1 the arm bit keeps its value.
- R3: A byte write (`wr_req`=1) is accepted only when `arm_q`=1, `permit`=1 and `pending`=0. Any other write leaves `pending`, `arm_q` and the flash outputs untouched.
- R4: When `post_q`=0 or `cp_en`=0 at acceptance, `fl_req` is 1 in the very next cycle, with `fl_addr`/`fl_data` equal to the accepted address and data.
- R5: When `post_q`=1 and `cp_en`=1 at acceptance, the byte is held with `fl_req`=0. `fl_req` rises in the cycle after the first clock edge at which `cp_busy` is sampled 0, having been sampled 1 at the edge before.
- R6: A byte parked while `cp_busy` is already low is not released by that level. It waits for the next high-to-low transition of `cp_busy`.
- R7: `pending` is 1 from the cycle after acceptance until the cycle after `fl_ack` is sampled high together with `fl_req`. In that cycle both `pending` and `fl_req` return to 0.
- R8: A byte write attempted while `pending`=1 is dropped. The stored address and data are unchanged, and `arm_q` is unchanged.
- R9: `arm_q` is 0 in the cycle after every accepted byte. Acceptance takes priority over a same-cycle control write.
- R10: While `fl_req`=1 and `fl_ack`=0, `fl_req`, `fl_addr` and `fl_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_arm | input | 1 | Value for the byte-write arm bit |
| ctl_post | input | 1 | Value for the posting control bit |
| irq_en | input | 1 | Global interrupt enable; blocks arm writes |
| wr_req | input | 1 | Processor byte-write request |
| wr_addr | input | AW | Byte-write address |
| wr_data | input | DW | Byte-write data |
| permit | input | 1 | Flash modification allowed |
| cp_en | input | 1 | Coprocessor enabled |
| cp_busy | input | 1 | Coprocessor busy |
| fl_ack | input | 1 | Flash port accepts the presented byte |
| fl_req | output | 1 | Byte presented to the flash port |
| fl_addr | output | AW | Presented address |
| fl_data | output | DW | Presented data |
| pending | output | 1 | Slot holds a byte not yet accepted by flash |
| arm_q | output | 1 | Current byte-write arm bit |
| post_q | output | 1 | Current posting control bit |

## Verification
The bench targets four cases:

- **Busy already low at capture.** A design that released on the busy level instead of its falling edge would issue the byte at once.
- **Second write during pending.** A design that let this write through would overwrite the held address or consume the arm bit.
- **Arm attempt with interrupts enabled.** A design missing that guard would let the byte through.
- **Ack arriving several cycles late.** A design whose outputs drift or whose pending flag drops early would present a changed byte or show the slot empty while the flash has not taken it.

A behavioural reference model is compared on every cycle, so off-by-one release timing shows up as a mismatch.

// File: rtl/pfw_pkg.sv
// Package: shared types for the posted flash write buffer.
// Assumes: nothing beyond a single clock domain.
package pfw_pkg;

    // Occupancy of the single holding slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,  // nothing stored
        SLOT_HELD  = 2'd1,  // parked, waiting for busy to fall
        SLOT_ISSUE = 2'd2   // presented to flash, waiting for ack
    } slot_state_e;

endpackage

// File: rtl/pfw_fall_det.sv
// Module: pfw_fall_det
// Detects a high-to-low transition of a level input by comparing it with
// a registered copy taken on the previous clock edge.
// Assumes: the input is synchronous to clk.
module pfw_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);

    logic level_q;

    // Keep last cycle's sample; reset to 0 so no edge appears after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign fall = level_q & ~level;

endmodule

// File: rtl/pfw_ctl.sv
// Module: pfw_ctl
// Holds the byte-write arm bit and the posting control bit.
// The arm bit is guarded by the interrupt enable and self-clears on use.
// Assumes: consume is a one-cycle pulse per accepted byte.
module pfw_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wr_arm,
    input  logic wr_post,
    input  logic irq_en,
    input  logic consume,
    output logic arm,
    output logic post
);

    // Arm bit: use clears it first, otherwise an unguarded write loads it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 arm <= 1'b0;
        else if (consume)           arm <= 1'b0;
        else if (we && !irq_en)     arm <= wr_arm;
    end

    // Posting bit: loaded on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)   post <= 1'b0;
        else if (we)  post <= wr_post;
    end

endmodule

// File: rtl/pfw_slot.sv
// Module: pfw_slot
// Single-entry holding slot with the flash-side request handshake.
// A byte is loaded on accept. It is either issued at once or parked until a
// busy fall is reported, and it leaves on fl_ack while issued.
// Assumes: accept is only raised while the slot is empty.
module pfw_slot
    import pfw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          park,
    input  logic          release_ev,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          fl_ack,
    output logic          empty,
    output logic          fl_req,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_data
);

    slot_state_e state_q, state_d;

    // Next-state selection for the slot occupancy.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (accept)     state_d = park ? SLOT_HELD : SLOT_ISSUE;
            SLOT_HELD:  if (release_ev) state_d = SLOT_ISSUE;
            SLOT_ISSUE: if (fl_ack)     state_d = SLOT_EMPTY;
            default:                    state_d = SLOT_EMPTY;
        endcase
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // Payload register: loaded only when an empty slot accepts a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_addr <= '0;
            fl_data <= '0;
        end else if (accept && state_q == SLOT_EMPTY) begin
            fl_addr <= addr_in;
            fl_data <= data_in;
        end
    end

    assign empty  = (state_q == SLOT_EMPTY);
    assign fl_req = (state_q == SLOT_ISSUE);

endmodule

// File: rtl/flash_post_buf.sv
// Module: flash_post_buf
// Posted flash byte-write buffer. A permitted, armed write goes straight
// to the flash port, or into a one-deep slot when posting is active. A
// parked byte is released when the coprocessor busy input falls.
// Assumes: all inputs are synchronous to clk; fl_ack is only meaningful
// while fl_req is high.
module flash_post_buf
    import pfw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_arm,
    input  logic          ctl_post,
    input  logic          irq_en,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          permit,
    input  logic          cp_en,
    input  logic          cp_busy,
    input  logic          fl_ack,
    output logic          fl_req,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_data,
    output logic          pending,
    output logic          arm_q,
    output logic          post_q
);

    logic slot_empty;
    logic busy_fall;
    logic accept;
    logic park;

    // Posting is active only with both the control bit and coprocessor on.
    assign park   = post_q & cp_en;
    // A byte is taken when armed, permitted and the slot is free.
    assign accept = wr_req & arm_q & permit & slot_empty;
    assign pending = ~slot_empty;

    pfw_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .wr_arm  (ctl_arm),
        .wr_post (ctl_post),
        .irq_en  (irq_en),
        .consume (accept),
        .arm     (arm_q),
        .post    (post_q)
    );

    pfw_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cp_busy),
        .fall  (busy_fall)
    );

    pfw_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .park       (park),
        .release_ev (busy_fall),
        .addr_in    (wr_addr),
        .data_in    (wr_data),
        .fl_ack     (fl_ack),
        .empty      (slot_empty),
        .fl_req     (fl_req),
        .fl_addr    (fl_addr),
        .fl_data    (fl_data)
    );

endmodule

// File: rtl/pfw_checker.sv
// Module: pfw_checker
// Temporal properties of flash_post_buf, attached through bind.
// Assumes: connected to the top-level ports plus the accept and busy-fall
// signals driven by separate logic inside the top.
module pfw_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_we,
    input logic          irq_en,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          permit,
    input logic          cp_en,
    input logic          fl_ack,
    input logic          fl_req,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_data,
    input logic          pending,
    input logic          arm_q,
    input logic          post_q,
    input logic          accept,
    input logic          busy_fall
);

    assert_arm_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && irq_en && !accept) |=> (arm_q == $past(arm_q)));

    assert_no_permit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !permit && !pending) |=> !pending);

    assert_direct_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(post_q && cp_en)) |=>
            (fl_req && fl_addr == $past(wr_addr) && fl_data == $past(wr_data)));

    assert_parked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && post_q && cp_en) |=> (!fl_req && pending));

    assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) |-> ($past(busy_fall) || $past(accept && !(post_q && cp_en))));

    assert_wait_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !fl_req && !busy_fall) |=> !fl_req);

    assert_accept_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pending);

    assert_ack_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack) |=> (!fl_req && !pending));

    assert_drop_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && pending && !fl_ack && !ctl_we) |=>
            ($stable(fl_addr) && $stable(fl_data) && pending && arm_q == $past(arm_q)));

    assert_arm_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !arm_q);

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_data)));

endmodule

bind flash_post_buf pfw_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .irq_en    (irq_en),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .permit    (permit),
    .cp_en     (cp_en),
    .fl_ack    (fl_ack),
    .fl_req    (fl_req),
    .fl_addr   (fl_addr),
    .fl_data   (fl_data),
    .pending   (pending),
    .arm_q     (arm_q),
    .post_q    (post_q),
    .accept    (accept),
    .busy_fall (busy_fall)
);

// File: tb/sim_flash_post_buf.sv
// Bench for flash_post_buf: directed scenarios plus a behavioural
// reference model compared on every falling clock edge.
module sim_flash_post_buf;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0, ctl_arm = 1'b0, ctl_post = 1'b0, irq_en = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          permit = 1'b1, cp_en = 1'b0, cp_busy = 1'b0, fl_ack = 1'b0;
    logic          fl_req, pending, arm_q, post_q;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_data;

    int total = 0;
    int bad = 0;
    int ack_lat = 2;
    int wait_cnt = 0;
    bit done = 1'b0;

    // reference model state: 0 empty, 1 parked, 2 issued
    int          m_state = 0;
    bit          m_arm = 0, m_post = 0, m_busy_q = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_post_buf #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_arm(ctl_arm),
        .ctl_post(ctl_post), .irq_en(irq_en), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .permit(permit),
        .cp_en(cp_en), .cp_busy(cp_busy), .fl_ack(fl_ack),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_data(fl_data),
        .pending(pending), .arm_q(arm_q), .post_q(post_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances on each rising edge from the input values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_arm = 0; m_post = 0; m_busy_q = 0;
            m_addr = '0; m_data = '0;
        end else begin
            bit acc, fall, nxt_arm, nxt_post;
            int nxt_state;
            fall = m_busy_q && !cp_busy;
            acc  = wr_req && m_arm && permit && (m_state == 0);
            nxt_state = m_state;
            if (m_state == 0 && acc) begin
                nxt_state = (m_post && cp_en) ? 1 : 2;
                m_addr = wr_addr;
                m_data = wr_data;
            end else if (m_state == 1 && fall) nxt_state = 2;
            else if (m_state == 2 && fl_ack) nxt_state = 0;
            nxt_arm  = m_arm;
            nxt_post = m_post;
            if (acc) nxt_arm = 0;
            else if (ctl_we && !irq_en) nxt_arm = ctl_arm;
            if (ctl_we) nxt_post = ctl_post;
            m_state = nxt_state; m_arm = nxt_arm; m_post = nxt_post;
            m_busy_q = cp_busy;
        end
    end

    // Per-cycle comparison and flash acknowledge responder.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 pending vs model", pending, (m_state != 0));
            check("R5 fl_req vs model", fl_req, (m_state == 2));
            check("R9 arm vs model", arm_q, m_arm);
            check("R2 post vs model", post_q, m_post);
            if (m_state == 2) begin
                check("R10 fl_addr vs model", fl_addr, m_addr);
                check("R10 fl_data vs model", fl_data, m_data);
            end
        end
        if (fl_req) wait_cnt++; else wait_cnt = 0;
        fl_ack = fl_req && (wait_cnt > ack_lat);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input bit a, input bit p);
        ctl_we = 1'b1; ctl_arm = a; ctl_post = p;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20 && pending; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pending", pending, 0);
        check("R1 arm", arm_q, 0);
        check("R1 post", post_q, 0);
        check("R1 fl_req", fl_req, 0);

        // R2: arm write blocked by interrupt enable, post still loads
        irq_en = 1'b1;
        ctl(1, 1);
        check("R2 arm blocked", arm_q, 0);
        check("R2 post loaded", post_q, 1);
        irq_en = 1'b0;
        ctl(1, 0);
        check("R2 arm loaded", arm_q, 1);

        // R3: no permit -> discarded, arm kept
        permit = 1'b0;
        put(16'h1111, 8'h11);
        check("R3 no permit pending", pending, 0);
        check("R3 no permit arm", arm_q, 1);
        permit = 1'b1;

        // R4 / R9 / R10 / R7: direct write with slow ack
        ack_lat = 3;
        put(16'h2345, 8'hA5);
        check("R4 direct fl_req", fl_req, 1);
        check("R4 direct addr", fl_addr, 16'h2345);
        check("R4 direct data", fl_data, 8'hA5);
        check("R9 arm cleared", arm_q, 0);
        cyc(2);
        check("R10 held addr", fl_addr, 16'h2345);
        drain();
        check("R7 drained", pending, 0);
        check("R7 req dropped", fl_req, 0);

        // R3: unarmed write ignored
        put(16'h0BAD, 8'hBD);
        check("R3 unarmed", pending, 0);

        // R4: posting bit on but coprocessor off -> direct
        ctl(1, 1);
        put(16'h3000, 8'h30);
        check("R4 cp off direct", fl_req, 1);
        drain();

        // R5: parked while busy high, released on fall
        cp_en = 1'b1; cp_busy = 1'b1;
        ctl(1, 1);
        put(16'h4444, 8'h44);
        check("R5 parked pending", pending, 1);
        check("R5 parked no req", fl_req, 0);
        // R8: rearm and attempt a second byte while pending
        ctl(1, 1);
        put(16'h5555, 8'h55);
        check("R8 arm kept", arm_q, 1);
        cyc(3);
        check("R5 still parked", fl_req, 0);
        cp_busy = 1'b0;
        @(negedge clk);
        check("R5 released", fl_req, 1);
        check("R8 first addr kept", fl_addr, 16'h4444);
        check("R8 first data kept", fl_data, 8'h44);
        drain();

        // R6: busy already low at capture waits for the next fall
        ack_lat = 0;
        put(16'h6666, 8'h66);
        check("R6 parked", pending, 1);
        cyc(5);
        check("R6 level ignored", fl_req, 0);
        cp_busy = 1'b1;
        @(negedge clk);
        check("R6 rise no release", fl_req, 0);
        cp_busy = 1'b0;
        @(negedge clk);
        check("R6 fall release", fl_req, 1);
        check("R6 addr", fl_addr, 16'h6666);
        drain();
        check("R7 final empty", pending, 0);

        cyc(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule